// File: doc/BRIEF.md
# Latched Real-Time Clock Register Bank

This block is the time-keeping part of a cartridge bank mapper. It keeps a live calendar counter of seconds, minutes, hours and a 9-bit day count, advanced by a single-cycle one-second tick. Software never reads the live counters directly. It first takes a snapshot with a two-write latch sequence, then reads the frozen copy through the external-RAM address window. While a clock register is mapped into that window, it replaces the RAM there.

The bank-select region of the CPU write bus decides what the window shows: either a RAM bank number or one of five clock registers. A control register groups a halt bit, a sticky day-overflow flag and the ninth day bit. The same block also holds the ROM bank number, whose zero value is remapped to one. Reads are combinational from the address. Writes take effect on the clock edge.

Top module: `rtc_latch_bank`

## Requirements
- R1: After reset, rom_bank_o is 1, ram_bank_o is 0 and clk_sel_o is 0. All live and latched registers are zero, and the latch sequence is unarmed.
- R2: A write with addr_i[15:13]=3'b001 stores wdata_i[6:0] as the ROM bank. A stored value of 0 becomes 1.
- R3: A write with addr_i[15:13]=3'b010 and data 0x00–0x03 sets ram_bank_o to wdata_i[1:0] and clears clk_sel_o. Data 0x08..0x0C sets clk_sel_o and maps, in that order, seconds, minutes, hours, day low or control. Any other data value is ignored.
- R4: A write of 0x01 with addr_i[15:13]=3'b011 copies the live registers into the latched registers only if the previous write to that region was 0x00. The copy takes the values from before any update in the same cycle.
- R5: The latched seconds, minutes and hours are zero-extended to 8 bits. Latched day low is day[7:0]. Latched control is the live control bits 7:1, with bit 0 equal to day[8].
- R6: A write with addr_i[15:13]=3'b101 while clk_sel_o is 1 loads the mapped live register. Seconds and minutes take wdata_i[5:0], hours take wdata_i[4:0], and day low takes wdata_i[7:0]. For control, bits 6:1 take the data, bit 7 becomes old bit 7 OR wdata_i[7], and day[8] takes wdata_i[0].
- R7: On each counted tick, seconds increment. A value of 59 or more wraps to 0 and carries into minutes, which behave the same way. Hours wrap from 23 or more to 0 and carry into the day count.
- R8: A day carry at day 511 wraps the day count to 0 and sets control bit 7. Bit 7 is cleared only by reset.
- R9: While control bit 6 (halt) is set, ticks have no effect on the live registers.
- R10: A live-register write in the same cycle as a tick suppresses that tick entirely.
- R11: rdata_o shows the latched value of the mapped register when addr_i[15:13]=3'b101 and clk_sel_o is 1. Otherwise it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | CPU write strobe |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| tick_i | input | 1 | One-second tick, one cycle wide |
| rdata_o | output | 8 | Read data for the clock window |
| clk_sel_o | output | 1 | A clock register is mapped into the window |
| rom_bank_o | output | 7 | Selected ROM bank |
| ram_bank_o | output | 2 | Selected RAM bank |

## Verification
The counter is driven from values set just below each wrap point (59/59/23/511), so a single tick exercises every carry and the overflow flag in one step. This separates a carry-chain error from a plain increment error. Latch sequences are varied: 1 alone, 0-2-1, 0-1, and 0-1 coinciding with a tick. These show whether arming depends only on the immediately preceding write, and whether the snapshot takes pre-tick values. A long mixed run of ticks, register writes, halts and latches is compared cycle by cycle against a behavioural model, which catches priority mistakes between writes and ticks.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ROM_W  = 7;
  localparam int unsigned RAM_W  = 2;
  localparam int unsigned SEC_W  = 6;
  localparam int unsigned HR_W   = 5;
  localparam int unsigned DAY_W  = 9;
  localparam int unsigned CTL_W  = 7;  // control bits 7:1

  typedef enum logic [2:0] {
    REG_SEC = 3'd0, REG_MIN = 3'd1, REG_HR = 3'd2, REG_DAY = 3'd3, REG_CTL = 3'd4
  } rtc_reg_e;

  typedef enum logic [2:0] {
    RGN_ROM = 3'b001, RGN_BANK = 3'b010, RGN_LATCH = 3'b011, RGN_WIN = 3'b101
  } rtc_rgn_e;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [SEC_W-1:0] min;
    logic [HR_W-1:0]  hr;
    logic [DAY_W-1:0] day;
    logic [CTL_W-1:0] ctl;
  } rtc_time_t;
endpackage

// File: rtl/rtc_wrap_stage.sv
module rtc_wrap_stage #(
  parameter int unsigned W    = 6,
  parameter int unsigned LAST = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LastV = LAST[W-1:0];

  logic [W-1:0] val_q;

  assign carry_o = inc_i && (val_q >= LastV);
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      val_q <= '0;
    else if (ld_i)    val_q <= ld_val_i;
    else if (inc_i)   val_q <= carry_o ? '0 : val_q + 1'b1;
  end
endmodule

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
  import rtc_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  rtc_reg_e          idx_i,
  input  logic [DATA_W-1:0] d_i,
  output rtc_time_t         live_o,
  output logic              run_o
);
  logic [DAY_W-1:0] day_q;
  logic [CTL_W-1:0] ctl_q;
  logic             c_sec, c_min, c_hr;

  // halt is control bit 6, stored at ctl_q[5]
  assign run_o = tick_i && !ctl_q[5] && !we_i;

  rtc_wrap_stage #(.W(SEC_W), .LAST(59)) u_sec (
    .clk_i, .rst_ni, .inc_i(run_o), .ld_i(we_i && idx_i == REG_SEC),
    .ld_val_i(d_i[SEC_W-1:0]), .val_o(live_o.sec), .carry_o(c_sec));

  rtc_wrap_stage #(.W(SEC_W), .LAST(59)) u_min (
    .clk_i, .rst_ni, .inc_i(c_sec), .ld_i(we_i && idx_i == REG_MIN),
    .ld_val_i(d_i[SEC_W-1:0]), .val_o(live_o.min), .carry_o(c_min));

  rtc_wrap_stage #(.W(HR_W), .LAST(23)) u_hr (
    .clk_i, .rst_ni, .inc_i(c_min), .ld_i(we_i && idx_i == REG_HR),
    .ld_val_i(d_i[HR_W-1:0]), .val_o(live_o.hr), .carry_o(c_hr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q <= '0;
      ctl_q <= '0;
    end else if (we_i) begin
      if (idx_i == REG_DAY) day_q[7:0] <= d_i;
      if (idx_i == REG_CTL) begin
        day_q[DAY_W-1] <= d_i[0];
        ctl_q          <= {ctl_q[CTL_W-1] | d_i[7], d_i[6:1]};
      end
    end else if (c_hr) begin
      if (&day_q) begin
        day_q           <= '0;
        ctl_q[CTL_W-1]  <= 1'b1;
      end else begin
        day_q <= day_q + 1'b1;
      end
    end
  end

  assign live_o.day = day_q;
  assign live_o.ctl = ctl_q;
endmodule

// File: rtl/rtc_bank_decode.sv
module rtc_bank_decode
  import rtc_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ROM_W-1:0]  rom_bank_o,
  output logic [RAM_W-1:0]  ram_bank_o,
  output logic              clk_sel_o,
  output rtc_reg_e          idx_o,
  output logic              latch_o,
  output logic              live_we_o,
  output logic              win_o
);
  logic [2:0] rgn;
  logic       armed_q;
  logic       wr_rom, wr_bank, wr_latch;
  logic       pick_ram, pick_clk;

  assign rgn      = addr_i[ADDR_W-1:ADDR_W-3];
  assign win_o    = (rgn == RGN_WIN);
  assign wr_rom   = wr_en_i && (rgn == RGN_ROM);
  assign wr_bank  = wr_en_i && (rgn == RGN_BANK);
  assign wr_latch = wr_en_i && (rgn == RGN_LATCH);
  assign pick_ram = wdata_i <= 8'h03;
  assign pick_clk = (wdata_i >= 8'h08) && (wdata_i <= 8'h0C);

  assign latch_o   = wr_latch && armed_q && (wdata_i == 8'h01);
  assign live_we_o = wr_en_i && win_o && clk_sel_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_o <= ROM_W'(1);
      ram_bank_o <= '0;
      clk_sel_o  <= 1'b0;
      idx_o      <= REG_SEC;
      armed_q    <= 1'b0;
    end else begin
      if (wr_rom) rom_bank_o <= (wdata_i[ROM_W-1:0] == '0) ? ROM_W'(1) : wdata_i[ROM_W-1:0];
      if (wr_bank && pick_ram) begin
        ram_bank_o <= wdata_i[RAM_W-1:0];
        clk_sel_o  <= 1'b0;
      end
      if (wr_bank && pick_clk) begin
        clk_sel_o <= 1'b1;
        idx_o     <= rtc_reg_e'(wdata_i[2:0] - 3'd0);
      end
      if (wr_latch) armed_q <= (wdata_i == 8'h00);
    end
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_i,
  input  rtc_time_t         live_i,
  input  rtc_reg_e          idx_i,
  output logic [DATA_W-1:0] snap_o,
  output logic [DATA_W-1:0] cap_sec_o
);
  localparam int unsigned NREG = 5;

  logic [DATA_W-1:0] cap_q [NREG];
  logic [DATA_W-1:0] nxt   [NREG];

  always_comb begin
    nxt[REG_SEC] = DATA_W'(live_i.sec);
    nxt[REG_MIN] = DATA_W'(live_i.min);
    nxt[REG_HR]  = DATA_W'(live_i.hr);
    nxt[REG_DAY] = live_i.day[7:0];
    nxt[REG_CTL] = {live_i.ctl, live_i.day[DAY_W-1]};
  end

  for (genvar g = 0; g < NREG; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cap_q[g] <= '0;
      else if (latch_i) cap_q[g] <= nxt[g];
    end
  end

  always_comb begin
    snap_o = '0;
    if (int'(idx_i) < NREG) snap_o = cap_q[idx_i];
  end

  assign cap_sec_o = cap_q[REG_SEC];
endmodule

// File: rtl/rtc_latch_bank.sv
module rtc_latch_bank
  import rtc_bank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_sel_o,
  output logic [ROM_W-1:0]  rom_bank_o,
  output logic [RAM_W-1:0]  ram_bank_o
);
  rtc_reg_e          idx;
  logic              latch, live_we, win, run;
  rtc_time_t         live;
  logic [DATA_W-1:0] snap, cap_sec;

  rtc_bank_decode u_dec (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .rom_bank_o, .ram_bank_o, .clk_sel_o,
    .idx_o(idx), .latch_o(latch), .live_we_o(live_we), .win_o(win));

  rtc_live_counter u_cnt (
    .clk_i, .rst_ni, .tick_i, .we_i(live_we), .idx_i(idx), .d_i(wdata_i),
    .live_o(live), .run_o(run));

  rtc_snapshot u_snap (
    .clk_i, .rst_ni, .latch_i(latch), .live_i(live), .idx_i(idx),
    .snap_o(snap), .cap_sec_o(cap_sec));

  assign rdata_o = (win && clk_sel_o) ? snap : '0;
endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk
  import rtc_bank_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              live_we,
  input logic              latch,
  input logic              win,
  input logic              clk_sel_o,
  input logic [ROM_W-1:0]  rom_bank_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] cap_sec,
  input rtc_time_t         live
);
  assert_rom_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_bank_o != '0);

  assert_sec_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !live.ctl[5] && !live_we && live.sec == 6'd59) |=> (live.sec == '0));

  assert_ovf_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(live.ctl[CTL_W-1]));

  assert_halt_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live.ctl[5] && !live_we) |=> $stable({live.sec, live.min, live.hr, live.day}));

  assert_latch_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch |=> (cap_sec == DATA_W'($past(live.sec))));

  assert_read_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(win && clk_sel_o) |-> (rdata_o == '0));
endmodule

bind rtc_latch_bank rtc_bank_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .live_we(live_we),
  .latch(latch), .win(win), .clk_sel_o(clk_sel_o), .rom_bank_o(rom_bank_o),
  .rdata_o(rdata_o), .cap_sec(cap_sec), .live(live));

// File: tb/rtc_latch_bank_tb.sv
module rtc_latch_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        tick_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        clk_sel_o;
  logic [6:0]  rom_bank_o;
  logic [1:0]  ram_bank_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  // reference model state
  int m_rom, m_ram, m_csel, m_idx, m_armed;
  int m_sec, m_min, m_hr, m_day, m_ctl;  // m_ctl holds bits 7:1 in place, bit 0 zero
  int m_lat[5];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_latch_bank dut_i (.*);

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
    end
  endtask

  function automatic int m_read(int a);
    if (((a >> 13) & 7) == 5 && m_csel != 0) return m_lat[m_idx];
    return 0;
  endfunction

  task automatic cmp_all();
    chk({tag, " rom_bank"}, rom_bank_o, m_rom);
    chk({tag, " ram_bank"}, ram_bank_o, m_ram);
    chk({tag, " clk_sel"}, clk_sel_o, m_csel);
    chk({tag, " rdata"}, rdata_o, m_read(addr_i));
  endtask

  task automatic m_reset();
    m_rom = 1; m_ram = 0; m_csel = 0; m_idx = 0; m_armed = 0;
    m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_ctl = 0;
    foreach (m_lat[i]) m_lat[i] = 0;
  endtask

  task automatic m_step(bit we, int a, int d, bit tk);
    int rgn = (a >> 13) & 7;
    bit lw = we && rgn == 5 && m_csel != 0;
    if (we && rgn == 3) begin
      if (m_armed != 0 && d == 1) begin
        m_lat[0] = m_sec; m_lat[1] = m_min; m_lat[2] = m_hr;
        m_lat[3] = m_day % 256; m_lat[4] = m_ctl | (m_day / 256);
      end
      m_armed = (d == 0);
    end
    if (we && rgn == 1) m_rom = ((d % 128) == 0) ? 1 : d % 128;
    if (we && rgn == 2) begin
      if (d <= 3) begin m_ram = d; m_csel = 0; end
      else if (d >= 8 && d <= 12) begin m_csel = 1; m_idx = d - 8; end
    end
    if (lw) begin
      case (m_idx)
        0: m_sec = d % 64;
        1: m_min = d % 64;
        2: m_hr  = d % 32;
        3: m_day = (m_day / 256) * 256 + d;
        default: begin
          m_day = (m_day % 256) + (d % 2) * 256;
          m_ctl = (m_ctl & 8'h80) | (d & 8'hFE);
        end
      endcase
    end else if (tk && (m_ctl & 8'h40) == 0) begin
      if (m_sec >= 59) begin
        m_sec = 0;
        if (m_min >= 59) begin
          m_min = 0;
          if (m_hr >= 23) begin
            m_hr = 0;
            if (m_day == 511) begin m_day = 0; m_ctl = m_ctl | 8'h80; end
            else m_day++;
          end else m_hr++;
        end else m_min++;
      end else m_sec++;
    end
  endtask

  task automatic cyc(bit we, int a, int d, bit tk);
    wr_en_i = we; addr_i = 16'(a); wdata_i = 8'(d); tick_i = tk;
    #1;
    cmp_all();
    m_step(we, a, d, tk);
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) cyc(0, 16'hA000, 0, 1);
  endtask

  task automatic do_latch();
    wr(16'h6000, 0);
    wr(16'h6000, 1);
  endtask

  // map register code and read it; checked against a hand value
  task automatic rd_reg(int code, int exp, string t);
    wr(16'h4000, code);
    wr_en_i = 0; tick_i = 0; addr_i = 16'hA123;
    #1;
    chk(t, rdata_o, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    tag = "R1";
    addr_i = 16'hA000; #1;
    chk("R1 rom_bank", rom_bank_o, 1);
    chk("R1 ram_bank", ram_bank_o, 0);
    chk("R1 clk_sel", clk_sel_o, 0);
    @(negedge clk_i);
    rd_reg(8'h08, 8'h00, "R1 latched seconds");
    wr(16'h6000, 1);  // unarmed after reset: no copy
    rd_reg(8'h0C, 8'h00, "R1 latched control");

    // R2 rom bank
    tag = "R2";
    wr(16'h2000, 8'h00); chk("R2 zero->1", rom_bank_o, 1);
    wr(16'h3FFF, 8'h85); chk("R2 7-bit mask", rom_bank_o, 5);
    wr(16'h2100, 8'h7F); chk("R2 max", rom_bank_o, 8'h7F);

    // R3 bank select
    tag = "R3";
    wr(16'h4000, 2);     chk("R3 ram bank", ram_bank_o, 2);
    wr(16'h5000, 8'h05); chk("R3 ignored ram", ram_bank_o, 2);
    chk("R3 ignored sel", clk_sel_o, 0);
    wr(16'h4000, 8'h0A); chk("R3 clock sel", clk_sel_o, 1);
    wr(16'h4000, 8'h0D); chk("R3 0x0D ignored", clk_sel_o, 1);
    wr(16'h4000, 1);     chk("R3 ram clears sel", clk_sel_o, 0);
    chk("R3 ram bank 1", ram_bank_o, 1);

    // R6 / R5 live writes just below every wrap
    tag = "R6";
    wr(16'h4000, 8'h08); wr(16'hA000, 59);
    wr(16'h4000, 8'h09); wr(16'hB000, 59);
    wr(16'h4000, 8'h0A); wr(16'hA010, 23);
    wr(16'h4000, 8'h0B); wr(16'hA000, 8'hFF);
    wr(16'h4000, 8'h0C); wr(16'hA000, 8'h01);
    do_latch();
    rd_reg(8'h08, 59, "R6 seconds");
    rd_reg(8'h09, 59, "R6 minutes");
    rd_reg(8'h0A, 23, "R6 hours");
    rd_reg(8'h0B, 8'hFF, "R5 day low");
    rd_reg(8'h0C, 8'h01, "R5 control bit0=day8");

    // R7 / R8 full carry chain and overflow
    tag = "R7";
    tick_n(1);
    do_latch();
    rd_reg(8'h08, 0, "R7 seconds wrap");
    rd_reg(8'h09, 0, "R7 minutes wrap");
    rd_reg(8'h0A, 0, "R7 hours wrap");
    rd_reg(8'h0B, 0, "R8 day wrap");
    rd_reg(8'h0C, 8'h80, "R8 overflow set");

    // R10 write beats tick
    tag = "R10";
    wr(16'h4000, 8'h08);
    cyc(1, 16'hA000, 10, 1);
    do_latch();
    rd_reg(8'h08, 10, "R10 tick suppressed");

    // R9 halt
    tag = "R9";
    wr(16'h4000, 8'h0C); wr(16'hA000, 8'h40);
    tick_n(5);
    do_latch();
    rd_reg(8'h08, 10, "R9 halted seconds");
    rd_reg(8'h0C, 8'hC0, "R8 sticky under write");
    wr(16'hA000, 8'h00);
    tick_n(2);
    do_latch();
    rd_reg(8'h08, 12, "R9 resumed");
    rd_reg(8'h0C, 8'h80, "R8 still sticky");

    // R4 latch sequence
    tag = "R4";
    tick_n(3);
    wr(16'h6000, 1);
    rd_reg(8'h08, 12, "R4 lone 1 no latch");
    wr(16'h6000, 0); wr(16'h6000, 2); wr(16'h6000, 1);
    rd_reg(8'h08, 12, "R4 0-2-1 no latch");
    wr(16'h6000, 0);
    cyc(1, 16'h6000, 1, 1);  // latch together with tick: pre-tick value
    rd_reg(8'h08, 15, "R4 pre-tick capture");
    do_latch();
    rd_reg(8'h08, 16, "R4 0-1 latches");

    // R11 read gating
    tag = "R11";
    wr_en_i = 0; addr_i = 16'h8000; #1;
    chk("R11 outside window", rdata_o, 0);
    @(negedge clk_i);
    wr(16'h4000, 3);
    wr_en_i = 0; addr_i = 16'hA000; #1;
    chk("R11 ram mapped", rdata_o, 0);
    @(negedge clk_i);

    // mixed run against the model (R7 R8 R9 R10 R4)
    tag = "R7 mixed";
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 9);
      bit tk = $urandom_range(0, 1);
      case (op)
        0: cyc(1, 16'h4000, 8 + $urandom_range(0, 4), tk);
        1: cyc(1, 16'hA000, $urandom_range(0, 255), tk);
        2: cyc(1, 16'h6000, $urandom_range(0, 1), tk);
        3: cyc(1, 16'h4000 + $urandom_range(0, 8191), $urandom_range(0, 15), tk);
        4: cyc(1, 16'hA000, 8'h3A + $urandom_range(0, 2), tk);
        default: cyc(0, 16'hA000 + $urandom_range(0, 8191), 0, tk);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule